// File: doc/BRIEF.md
# Flash Program Suspend Controller

This block holds the mode state of a multi-bank flash model while a program (write) operation runs, and lets the host pause that write so it can read the array. Its inputs are decoded command strobes: suspend, resume, and entry and exit of identifier reads and query-table reads. Each strobe comes with a command address. The block also sees a start/done handshake from the program engine and a flag that says whether the device is sitting in an erase-suspended read state. The block returns its current mode, a pause request to the program engine, a busy flag, and a read-path selector. It also marks reads that hit the location whose write was interrupted.

A suspend is taken only while a write is in progress and only when the command names the bank being written. The block then holds the engine paused for `TSUSP` clock cycles before it allows reads. A resume brings the write back and restores the status flag on the read path. The resume is refused while an identifier read or a query read is still open. The program sub-mode (normal, fast, accelerated) and the fact that the write was started from an erase-suspended state are both kept across the pause.

Top module: `flash_psusp_ctrl`

## Requirements
- R1: After a hardware reset, from any state and taking effect at once, `mode` is READ (0), `pause_req` and `busy` are 0, `rd_sel` is ARRAY (0), `rd_undef` is 0 and `wr_bank` is 0.
- R2: `prog_start` in READ moves to WRITE (1) on the next edge. It latches bank = `prog_addr[AW-1:AW-BANK_BITS]`, the full address and `prog_kind_in`. In WRITE `busy` is 1 and `rd_sel` is STATUS (1). `prog_done` in WRITE or SUSP_WAIT returns to READ.
- R3: `cmd_suspend` is acted on only in WRITE. In READ, SUSP_READ, SUSP_ID or SUSP_QRY the mode is unchanged, and a second suspend while suspended is ignored.
- R4: Suspend and resume take effect only when `cmd_addr[AW-1:AW-BANK_BITS]` equals the latched write bank. Otherwise the mode is unchanged.
- R5: An accepted suspend enters SUSP_WAIT (2) on the next edge. The block stays there with `pause_req`=1, `busy`=1 and `rd_sel`=STATUS, and enters SUSP_READ (3) exactly `TSUSP` edges after the edge that took the command. In SUSP_READ `pause_req`=1, `busy`=0 and `rd_sel`=ARRAY.
- R6: From SUSP_READ, ID entry goes to SUSP_ID (4) with `rd_sel`=ID (2), and query entry goes to SUSP_QRY (5) with `rd_sel`=QUERY (3). The matching exit returns to SUSP_READ.
- R7: `rd_undef` is 1 exactly when the mode is SUSP_READ and `rd_addr` equals the latched write address.
- R8: A bank-matching resume in SUSP_READ returns to WRITE with `pause_req`=0 and `rd_sel`=STATUS. A resume in SUSP_ID or SUSP_QRY is ignored.
- R9: `prog_kind` (0 normal, 1 fast, 2 accelerated) holds its latched value through suspend and resume.
- R10: `prog_start` is accepted while `es_active`=1. `wr_nested` then reads 1 for that write, and such a write can be suspended and resumed like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| es_active | input | 1 | Device is in an erase-suspended read state |
| prog_start | input | 1 | Program engine begins a write |
| prog_addr | input | AW | Address of the write being started |
| prog_kind_in | input | 2 | Program sub-mode of the write being started |
| prog_done | input | 1 | Program engine finished the write |
| cmd_addr | input | AW | Address carried by the command strobe |
| cmd_suspend | input | 1 | Suspend command strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_id_enter | input | 1 | Identifier-read entry strobe |
| cmd_id_exit | input | 1 | Identifier-read exit strobe |
| cmd_qry_enter | input | 1 | Query-read entry strobe |
| cmd_qry_exit | input | 1 | Query-read exit strobe |
| rd_addr | input | AW | Address of the current array read |
| mode | output | 3 | Current mode code |
| pause_req | output | 1 | Pause request to the program engine |
| busy | output | 1 | Device reports busy |
| rd_sel | output | 2 | Read-path selector: array, status, ID, query |
| rd_undef | output | 1 | Current read hits the interrupted location |
| wr_bank | output | BANK_BITS | Bank of the write in progress |
| prog_kind | output | 2 | Latched program sub-mode |
| wr_nested | output | 1 | Current write was started from erase suspend |

## Verification
A table of command sequences walks the main path. Each suspend is tried first with the wrong bank, then with the right bank, then again while already suspended, so that bank rejection, mode gating and repeat rejection each show up as a distinct mode outcome. The resume is tried while ID and query reads are open and again after they are closed, which separates "blocked" from "taken". Directed cases follow. One counts the latency edge by edge. One compares `rd_undef` for the interrupted address against a neighbouring address. One carries an accelerated write that was started under erase suspend through a full pause. One ends a write during the latency, and one resets in the middle of a suspend.

// File: rtl/psusp_pkg.sv
package psusp_pkg;

  typedef enum logic [2:0] {
    M_READ      = 3'd0,
    M_WRITE     = 3'd1,
    M_SUSP_WAIT = 3'd2,
    M_SUSP_READ = 3'd3,
    M_SUSP_ID   = 3'd4,
    M_SUSP_QRY  = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ID     = 2'd2,
    SEL_QUERY  = 2'd3
  } rdsel_e;

  // Read-path source chosen by each mode.
  function automatic rdsel_e sel_for(mode_e m);
    case (m)
      M_WRITE, M_SUSP_WAIT: sel_for = SEL_STATUS;
      M_SUSP_ID:            sel_for = SEL_ID;
      M_SUSP_QRY:           sel_for = SEL_QUERY;
      default:              sel_for = SEL_ARRAY;
    endcase
  endfunction

  // The program engine is held while the write is suspended or settling.
  function automatic logic paused_in(mode_e m);
    return (m == M_SUSP_WAIT) || (m == M_SUSP_READ) ||
           (m == M_SUSP_ID)   || (m == M_SUSP_QRY);
  endfunction

  function automatic logic busy_in(mode_e m);
    return (m == M_WRITE) || (m == M_SUSP_WAIT);
  endfunction

endpackage

// File: rtl/psusp_lat_timer.sv
module psusp_lat_timer #(
  parameter int TSUSP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (TSUSP < 2) ? 1 : $clog2(TSUSP + 1);
  localparam logic [CW-1:0] START = CW'(TSUSP - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= START;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/psusp_addr_match.sv
module psusp_addr_match #(
  parameter int AW        = 12,
  parameter int BANK_BITS = 2
) (
  input  logic [AW-1:0]        cmd_addr,
  input  logic [BANK_BITS-1:0] wr_bank,
  input  logic [AW-1:0]        rd_addr,
  input  logic [AW-1:0]        wr_addr,
  output logic                 bank_hit,
  output logic                 addr_hit
);
  localparam int SH = AW - BANK_BITS;

  assign bank_hit = ((cmd_addr >> SH) == AW'(wr_bank));
  assign addr_hit = (rd_addr == wr_addr);
endmodule

// File: rtl/flash_psusp_ctrl.sv
module flash_psusp_ctrl
  import psusp_pkg::*;
#(
  parameter int AW        = 12,
  parameter int BANK_BITS = 2,
  parameter int TSUSP     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 es_active,
  input  logic                 prog_start,
  input  logic [AW-1:0]        prog_addr,
  input  logic [1:0]           prog_kind_in,
  input  logic                 prog_done,
  input  logic [AW-1:0]        cmd_addr,
  input  logic                 cmd_suspend,
  input  logic                 cmd_resume,
  input  logic                 cmd_id_enter,
  input  logic                 cmd_id_exit,
  input  logic                 cmd_qry_enter,
  input  logic                 cmd_qry_exit,
  input  logic [AW-1:0]        rd_addr,
  output logic [2:0]           mode,
  output logic                 pause_req,
  output logic                 busy,
  output logic [1:0]           rd_sel,
  output logic                 rd_undef,
  output logic [BANK_BITS-1:0] wr_bank,
  output logic [1:0]           prog_kind,
  output logic                 wr_nested
);
  localparam int SH = AW - BANK_BITS;

  mode_e                mode_q, mode_d;
  logic [BANK_BITS-1:0] bank_q;
  logic [AW-1:0]        waddr_q;
  logic [1:0]           kind_q;
  logic                 nested_q;

  // Named internal events, used by the logic and by the assertions.
  logic bank_hit, addr_hit, tmr_expired;
  logic susp_accept, resume_accept, start_accept;

  psusp_addr_match #(.AW(AW), .BANK_BITS(BANK_BITS)) u_match (
    .cmd_addr (cmd_addr),
    .wr_bank  (bank_q),
    .rd_addr  (rd_addr),
    .wr_addr  (waddr_q),
    .bank_hit (bank_hit),
    .addr_hit (addr_hit)
  );

  psusp_lat_timer #(.TSUSP(TSUSP)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (susp_accept),
    .run     (mode_q == M_SUSP_WAIT),
    .expired (tmr_expired)
  );

  assign start_accept  = prog_start && (mode_q == M_READ);
  assign susp_accept   = cmd_suspend && bank_hit && (mode_q == M_WRITE) && !prog_done;
  assign resume_accept = cmd_resume && bank_hit && (mode_q == M_SUSP_READ);

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_READ:      if (start_accept) mode_d = M_WRITE;
      M_WRITE: begin
        if (prog_done)        mode_d = M_READ;
        else if (susp_accept) mode_d = M_SUSP_WAIT;
      end
      M_SUSP_WAIT: begin
        if (prog_done)        mode_d = M_READ;
        else if (tmr_expired) mode_d = M_SUSP_READ;
      end
      M_SUSP_READ: begin
        if (resume_accept)      mode_d = M_WRITE;
        else if (cmd_id_enter)  mode_d = M_SUSP_ID;
        else if (cmd_qry_enter) mode_d = M_SUSP_QRY;
      end
      M_SUSP_ID:   if (cmd_id_exit)  mode_d = M_SUSP_READ;
      M_SUSP_QRY:  if (cmd_qry_exit) mode_d = M_SUSP_READ;
      default:     mode_d = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_READ;
      bank_q   <= '0;
      waddr_q  <= '0;
      kind_q   <= '0;
      nested_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (start_accept) begin
        bank_q   <= BANK_BITS'(prog_addr >> SH);
        waddr_q  <= prog_addr;
        kind_q   <= prog_kind_in;
        nested_q <= es_active;
      end
    end
  end

  assign mode      = mode_q;
  assign pause_req = paused_in(mode_q);
  assign busy      = busy_in(mode_q);
  assign rd_sel    = sel_for(mode_q);
  assign rd_undef  = (mode_q == M_SUSP_READ) && addr_hit;
  assign wr_bank   = bank_q;
  assign prog_kind = kind_q;
  assign wr_nested = nested_q;

  // ---------------- assertions ----------------
  assert_susp_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SUSP_WAIT && $past(mode_q) != M_SUSP_WAIT) |-> $past(mode_q) == M_WRITE);

  assert_susp_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SUSP_WAIT && $past(mode_q) == M_WRITE) |-> $past(bank_hit));

  assert_wait_ends_on_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SUSP_READ && $past(mode_q) == M_SUSP_WAIT) |-> $past(tmr_expired));

  assert_wait_holds_engine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SUSP_WAIT) |-> (pause_req && busy));

  assert_resume_only_from_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WRITE && $past(mode_q) != M_WRITE && $past(mode_q) != M_READ)
      |-> $past(mode_q) == M_SUSP_READ);

  assert_context_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_READ && $past(mode_q) != M_READ) |-> ($stable(kind_q) && $stable(bank_q)));

endmodule

// File: tb/sim_flash_psusp_ctrl.sv
module sim_flash_psusp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, BB = 2, TS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic es_active = 0, prog_start = 0, prog_done = 0;
  logic [AW-1:0] prog_addr = '0, cmd_addr = '0, rd_addr = '0;
  logic [1:0] prog_kind_in = '0;
  logic cmd_suspend = 0, cmd_resume = 0, cmd_id_enter = 0, cmd_id_exit = 0;
  logic cmd_qry_enter = 0, cmd_qry_exit = 0;
  logic [2:0] mode; logic pause_req, busy, rd_undef, wr_nested;
  logic [1:0] rd_sel, prog_kind; logic [BB-1:0] wr_bank;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_psusp_ctrl #(.AW(AW), .BANK_BITS(BB), .TSUSP(TS)) u0 (
    .clk, .rst_n, .es_active, .prog_start, .prog_addr, .prog_kind_in, .prog_done,
    .cmd_addr, .cmd_suspend, .cmd_resume, .cmd_id_enter, .cmd_id_exit,
    .cmd_qry_enter, .cmd_qry_exit, .rd_addr, .mode, .pause_req, .busy, .rd_sel,
    .rd_undef, .wr_bank, .prog_kind, .wr_nested);

  // command codes of the table
  localparam logic [3:0] C_IDLE = 0, C_START = 1, C_DONE = 2, C_SUSP = 3, C_RES = 4,
                         C_IDI = 5, C_IDO = 6, C_QI = 7, C_QO = 8;

  // {cmd, addr, expected mode, expected pause, expected busy}
  localparam int NV = 19;
  localparam logic [20:0] VEC [NV] = '{
    {C_START, 12'h456, 3'd1, 1'b0, 1'b1},   // R2
    {C_SUSP,  12'h800, 3'd1, 1'b0, 1'b1},   // R4 wrong bank
    {C_SUSP,  12'h400, 3'd2, 1'b1, 1'b1},   // R5
    {C_IDLE,  12'h000, 3'd2, 1'b1, 1'b1},
    {C_IDLE,  12'h000, 3'd2, 1'b1, 1'b1},
    {C_IDLE,  12'h000, 3'd2, 1'b1, 1'b1},
    {C_IDLE,  12'h000, 3'd3, 1'b1, 1'b0},   // R5 after TS edges
    {C_SUSP,  12'h400, 3'd3, 1'b1, 1'b0},   // R3 repeat suspend
    {C_RES,   12'hC00, 3'd3, 1'b1, 1'b0},   // R4 wrong bank resume
    {C_IDI,   12'h000, 3'd4, 1'b1, 1'b0},   // R6
    {C_RES,   12'h400, 3'd4, 1'b1, 1'b0},   // R8 blocked
    {C_IDO,   12'h000, 3'd3, 1'b1, 1'b0},   // R6
    {C_QI,    12'h000, 3'd5, 1'b1, 1'b0},   // R6
    {C_RES,   12'h400, 3'd5, 1'b1, 1'b0},   // R8 blocked
    {C_QO,    12'h000, 3'd3, 1'b1, 1'b0},   // R6
    {C_RES,   12'h400, 3'd1, 1'b0, 1'b1},   // R8
    {C_DONE,  12'h000, 3'd0, 1'b0, 1'b0},   // R2
    {C_SUSP,  12'h400, 3'd0, 1'b0, 1'b0},   // R3 in read mode
    {C_RES,   12'h400, 3'd0, 1'b0, 1'b0}    // R4/R8 resume with no write
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one command for one edge, then sample 1 time unit after the edge
  task automatic issue(logic [3:0] c, logic [AW-1:0] a);
    @(negedge clk);
    cmd_addr = a; prog_addr = a;
    prog_start = (c == C_START); prog_done = (c == C_DONE);
    cmd_suspend = (c == C_SUSP); cmd_resume = (c == C_RES);
    cmd_id_enter = (c == C_IDI); cmd_id_exit = (c == C_IDO);
    cmd_qry_enter = (c == C_QI); cmd_qry_exit = (c == C_QO);
    @(posedge clk); #1;
    {prog_start, prog_done, cmd_suspend, cmd_resume} = '0;
    {cmd_id_enter, cmd_id_exit, cmd_qry_enter, cmd_qry_exit} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mode", 32'(mode), 0); chk("R1 pause", 32'(pause_req), 0);
    chk("R1 busy", 32'(busy), 0); chk("R1 rd_sel", 32'(rd_sel), 0);
    chk("R1 bank", 32'(wr_bank), 0); chk("R1 undef", 32'(rd_undef), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][20:17], VEC[i][16:5]);
      chk($sformatf("R2-8 vec%0d mode", i), 32'(mode), 32'(VEC[i][4:2]));
      chk($sformatf("R5 vec%0d pause", i), 32'(pause_req), 32'(VEC[i][1]));
      chk($sformatf("R5 vec%0d busy", i), 32'(busy), 32'(VEC[i][0]));
    end

    // R10 R9 R7: accelerated write started under erase suspend, bank 2
    es_active = 1'b1; prog_kind_in = 2'd2;
    issue(C_START, 12'hA33);
    es_active = 1'b0; prog_kind_in = 2'd0;
    chk("R2 rd_sel status", 32'(rd_sel), 1);
    chk("R2 wr_bank", 32'(wr_bank), 2);
    chk("R10 nested", 32'(wr_nested), 1);
    chk("R9 kind", 32'(prog_kind), 2);
    issue(C_SUSP, 12'h800);
    chk("R5 rd_sel wait", 32'(rd_sel), 1);
    for (int k = 1; k < TS; k++) issue(C_IDLE, 0);
    chk("R5 still waiting", 32'(mode), 2);
    issue(C_IDLE, 0);
    chk("R5 entered susp read", 32'(mode), 3);
    chk("R5 rd_sel array", 32'(rd_sel), 0);
    rd_addr = 12'hA33; #1;
    chk("R7 undef hit", 32'(rd_undef), 1);
    rd_addr = 12'hA34; #1;
    chk("R7 undef miss", 32'(rd_undef), 0);
    rd_addr = 12'hA33;
    issue(C_IDI, 0);
    chk("R6 rd_sel id", 32'(rd_sel), 2);
    chk("R7 no undef in id", 32'(rd_undef), 0);
    issue(C_IDO, 0);
    issue(C_QI, 0);
    chk("R6 rd_sel query", 32'(rd_sel), 3);
    issue(C_QO, 0);
    chk("R9 kind held suspended", 32'(prog_kind), 2);
    issue(C_RES, 12'hBFF);
    chk("R8 resume mode", 32'(mode), 1);
    chk("R8 rd_sel status", 32'(rd_sel), 1);
    chk("R8 pause off", 32'(pause_req), 0);
    chk("R9 kind after resume", 32'(prog_kind), 2);
    chk("R10 nested after resume", 32'(wr_nested), 1);

    // R2: write ends during the latency
    issue(C_SUSP, 12'h800);
    issue(C_DONE, 0);
    chk("R2 done in wait", 32'(mode), 0);
    chk("R2 pause released", 32'(pause_req), 0);

    // R1: reset in the middle of a suspend, bank 3
    issue(C_START, 12'hE00);
    issue(C_SUSP, 12'hC00);
    chk("R5 wait before reset", 32'(mode), 2);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 reset mode", 32'(mode), 0);
    chk("R1 reset bank", 32'(wr_bank), 0);
    chk("R1 reset pause", 32'(pause_req), 0);
    @(negedge clk); rst_n = 1'b1;
    issue(C_SUSP, 12'h000);
    chk("R3 suspend after reset ignored", 32'(mode), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule